// File: doc/BRIEF.md
# Oversampled Serial Receiver with Edge Resynchronization

This block receives asynchronous serial characters on an idle-high line. A one-cycle enable, pulsed at sixteen times the bit rate, drives all of its timing. The line first passes through a two-stage synchronizer. A falling edge on the idle line starts a candidate start bit. The candidate is accepted only if the line stays low until the middle of the bit. A shorter low pulse counts as noise, and the receiver goes back to waiting. After that, every data bit is sampled at its midpoint. Every level change seen on the line while a character is in flight restarts the bit-phase counter. This moves the sample point back to the centre of the bit that follows, so a sender running a little fast or a little slow is still read correctly.

A 2-bit length select sets the number of data bits to 5, 6, 7 or 8. Data arrives least significant bit first. When the stop bit is sampled, the character moves into a holding register and a data-ready flag and an interrupt request are raised. The next character can shift in while the host reads the previous one. The stop-bit level and any unread overwrite are reported with the character. A single-cycle read strobe from the host clears the ready flag, both error flags and the interrupt request.

Top module: `serial_rx_resync`

## Requirements
- R1: After reset, data_ready, frame_err, overrun and irq are 0 and rx_data is 0.
- R2: A low pulse that ends before the ninth consecutive sampling tick, counted from the tick that first sees it, is discarded. It raises no flag, and the next character is received correctly.
- R3: len_sel values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits arrive least significant first. rx_data holds bit i of the character in position i, and the bits above the length read as 0.
- R4: Once the stop bit has been sampled, data_ready is 1, and irq equals data_ready at all times.
- R5: If the line is low at the stop-bit sample point, frame_err is set for that character. The receiver then looks for no new start bit until the line has returned high.
- R6: If a character completes while data_ready is still 1 and no read strobe is present, overrun is set and rx_data takes the new character.
- R7: A read strobe with no character completing in the same cycle clears data_ready, frame_err, overrun and irq on the next clock edge.
- R8: Every line transition during a character restarts the bit phase. Characters sent at 14 or 18 clock-enable periods per bit are received correctly.
- R9: rx_data keeps its value while the next character shifts in, until that character's stop bit has been sampled.
- R10: The receiver advances only on cycles where sample_tick is 1. A line held for 32 clocks per bit, with a tick every second clock, is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Oversampling enable, 16 per bit |
| rxd | input | 1 | Serial line, idle high |
| len_sel | input | 2 | Data length select (5 + value bits) |
| rd_strobe | input | 1 | Host read acknowledge, one cycle |
| rx_data | output | 8 | Received character |
| data_ready | output | 1 | Character waiting for the host |
| frame_err | output | 1 | Stop bit of current character was low |
| overrun | output | 1 | An unread character was overwritten |
| irq | output | 1 | Interrupt request |

## Verification
With a tick on every clock, a level on rxd reaches the bit logic two clocks later, because of the synchronizer. data_ready and the flags then appear ten clocks after the stop bit starts on the pin: two synchronizer clocks plus eight ticks to the sample point. When ticks come every second clock, this latency roughly doubles. Frame results are therefore checked on a falling clock edge a full bit time after the stop bit has started, which is well past the due cycle in every case. The read strobe takes effect on the next rising edge and is checked at the falling edge after it. The mid-frame check on the held character is timed inside the second character, before that character's stop bit.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE   = 3'd0,
        RX_START  = 3'd1,
        RX_DATA   = 3'd2,
        RX_STOP   = 3'd3,
        RX_WAITHI = 3'd4
    } rx_state_e;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] ff_d;
    logic [STAGES-1:0] ff_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb ff_d = din;
        end else begin : g_chain
            always_comb ff_d = {ff_q[STAGES-2:0], din};
        end
    endgenerate

    // line idles high, so the chain resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= ff_d;
    end

    assign dout = ff_q[STAGES-1];
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int MAX_BITS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        line,
    input  logic [$clog2(MAX_BITS)-1:0] last_idx,
    output logic                        done,
    output logic [MAX_BITS-1:0]         done_data,
    output logic                        done_ferr
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(MAX_BITS);
    localparam logic [CNT_W-1:0] HALF   = CNT_W'(OSR / 2);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_state_e           st;
        logic                lvl;
        logic [CNT_W-1:0]    cnt;
        logic [IDX_W-1:0]    idx;
        logic [MAX_BITS-1:0] sr;
    } core_s;

    core_s s_d, s_q;
    logic             edge_seen;
    logic [CNT_W-1:0] phase;
    logic             done_d;
    logic             ferr_d;

    always_comb begin
        s_d       = s_q;
        done_d    = 1'b0;
        ferr_d    = 1'b0;
        edge_seen = (line != s_q.lvl);
        // phase 0 is the tick on which a transition is seen
        if (edge_seen)               phase = '0;
        else if (s_q.cnt == CNT_TOP) phase = '0;
        else                         phase = s_q.cnt + 1'b1;

        if (tick) begin
            s_d.lvl = line;
            s_d.cnt = phase;
            unique case (s_q.st)
                RX_IDLE: begin
                    if (!line) begin
                        s_d.st  = RX_START;
                        s_d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (line) begin
                        s_d.st = RX_IDLE;
                    end else if (phase == HALF) begin
                        s_d.st  = RX_DATA;
                        s_d.idx = '0;
                        s_d.sr  = '0;
                    end
                end
                RX_DATA: begin
                    if (phase == HALF) begin
                        s_d.sr[s_q.idx] = line;
                        if (s_q.idx == last_idx) s_d.st  = RX_STOP;
                        else                     s_d.idx = s_q.idx + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (phase == HALF) begin
                        done_d = 1'b1;
                        ferr_d = !line;
                        s_d.st = line ? RX_IDLE : RX_WAITHI;
                    end
                end
                RX_WAITHI: begin
                    if (line) s_d.st = RX_IDLE;
                end
                default: s_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= RX_IDLE;
            s_q.lvl <= 1'b1;
            s_q.cnt <= '0;
            s_q.idx <= '0;
            s_q.sr  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign done      = done_d;
    assign done_ferr = ferr_d;
    assign done_data = s_d.sr;
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         load_ferr,
    input  logic         rd,
    output logic [W-1:0] data,
    output logic         ready,
    output logic         ferr,
    output logic         ovr,
    output logic         req
);
    typedef struct packed {
        logic [W-1:0] data;
        logic         ready;
        logic         ferr;
        logic         ovr;
        logic         req;
    } hold_s;

    hold_s h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (load) begin
            h_d.data  = load_data;
            h_d.ferr  = load_ferr;
            h_d.ovr   = h_q.ready && !rd;
            h_d.ready = 1'b1;
            h_d.req   = 1'b1;
        end else if (rd) begin
            h_d.ready = 1'b0;
            h_d.ferr  = 1'b0;
            h_d.ovr   = 1'b0;
            h_d.req   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign data  = h_q.data;
    assign ready = h_q.ready;
    assign ferr  = h_q.ferr;
    assign ovr   = h_q.ovr;
    assign req   = h_q.req;
endmodule

// File: rtl/serial_rx_resync.sv
module serial_rx_resync #(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_tick,
    input  logic       rxd,
    input  logic [1:0] len_sel,
    input  logic       rd_strobe,
    output logic [7:0] rx_data,
    output logic       data_ready,
    output logic       frame_err,
    output logic       overrun,
    output logic       irq
);
    localparam int MAX_BITS = 8;
    localparam int MIN_BITS = 5;
    localparam int IDX_W    = $clog2(MAX_BITS);

    logic                line_s;
    logic [IDX_W-1:0]    last_idx;
    logic                core_done;
    logic [MAX_BITS-1:0] core_data;
    logic                core_ferr;

    assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(len_sel);

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    serial_rx_core #(.OSR(OSR), .MAX_BITS(MAX_BITS)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sample_tick),
        .line     (line_s),
        .last_idx (last_idx),
        .done     (core_done),
        .done_data(core_data),
        .done_ferr(core_ferr)
    );

    serial_rx_hold #(.W(MAX_BITS)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (core_done),
        .load_data(core_data),
        .load_ferr(core_ferr),
        .rd       (rd_strobe),
        .data     (rx_data),
        .ready    (data_ready),
        .ferr     (frame_err),
        .ovr      (overrun),
        .req      (irq)
    );
endmodule

// File: rtl/serial_rx_resync_chk.sv
module serial_rx_resync_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_strobe,
    input logic       core_done,
    input logic [7:0] rx_data,
    input logic       data_ready,
    input logic       frame_err,
    input logic       overrun,
    input logic       irq
);
    // R4
    irq_follows_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == data_ready);

    // R4
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> data_ready);

    // R6
    overrun_on_unread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && data_ready && !rd_strobe) |=> overrun);

    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !core_done) |=> (!data_ready && !frame_err && !overrun));

    // R9
    data_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_done |=> $stable(rx_data));

    // R5
    flags_need_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err || overrun) |-> data_ready);
endmodule

bind serial_rx_resync serial_rx_resync_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (rd_strobe),
    .core_done (core_done),
    .rx_data   (rx_data),
    .data_ready(data_ready),
    .frame_err (frame_err),
    .overrun   (overrun),
    .irq       (irq)
);

// File: tb/serial_rx_resync_bench.sv
module serial_rx_resync_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] len_sel = 2'd3;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       data_ready, frame_err, overrun, irq;

    int n_chk = 0;
    int n_fail = 0;
    int tick_div = 1;
    int tphase = 0;

    always #10 clk = ~clk;

    serial_rx_resync u_serial_rx_resync (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
        .len_sel(len_sel), .rd_strobe(rd_strobe), .rx_data(rx_data),
        .data_ready(data_ready), .frame_err(frame_err), .overrun(overrun), .irq(irq)
    );

    always @(negedge clk) begin
        tphase = (tphase + 1) % tick_div;
        sample_tick <= (tphase == 0);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold_line(input logic lvl, input int clks);
        rxd = lvl;
        repeat (clks) @(negedge clk);
    endtask

    task automatic send(input int val, input int nbits, input int bitclk, input logic stop_lvl);
        hold_line(1'b0, bitclk);
        for (int i = 0; i < nbits; i++) hold_line(val[i], bitclk);
        hold_line(stop_lvl, bitclk);
        hold_line(1'b1, bitclk);
    endtask

    task automatic host_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic check_frame(input string tag, input int exp, input bit ferr, input bit ovr);
        chk(data_ready == 1'b1, {tag, " R4 ready"}, data_ready, 1);
        chk(irq == 1'b1, {tag, " R4 irq"}, irq, 1);
        chk(rx_data == exp[7:0], {tag, " data"}, rx_data, exp);
        chk(frame_err == ferr, {tag, " R5 frame_err"}, frame_err, ferr);
        chk(overrun == ovr, {tag, " R6 overrun"}, overrun, ovr);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!data_ready && !frame_err && !overrun && !irq, "R1 flags after reset",
            {data_ready, frame_err, overrun, irq}, 0);
        chk(rx_data == 8'h00, "R1 data after reset", rx_data, 0);

        // R3 sweep of every length and every value
        for (int l = 0; l < 4; l++) begin
            len_sel = 2'(l);
            for (int v = 0; v < (1 << (5 + l)); v++) begin
                send(v, 5 + l, 16, 1'b1);
                check_frame("R3 sweep", v, 1'b0, 1'b0);
                host_read();
                chk(!data_ready && !irq, "R7 cleared by read", data_ready, 0);
            end
        end
        len_sel = 2'd3;

        // R2 short start pulse
        hold_line(1'b0, 6);
        hold_line(1'b1, 48);
        chk(!data_ready, "R2 glitch ignored", data_ready, 0);
        send(8'hA6, 8, 16, 1'b1);
        check_frame("R2 after glitch", 8'hA6, 1'b0, 1'b0);
        host_read();

        // R5 framing error, then line returns high
        send(8'h5A, 8, 16, 1'b0);
        check_frame("R5 low stop", 8'h5A, 1'b1, 1'b0);
        host_read();
        chk(!frame_err, "R7 frame_err cleared", frame_err, 0);
        send(8'h3C, 8, 16, 1'b1);
        check_frame("R5 recovery", 8'h3C, 1'b0, 1'b0);
        host_read();

        // R6 overrun and R9 held data
        send(8'h11, 8, 16, 1'b1);
        fork
            send(8'hE7, 8, 16, 1'b1);
            begin
                repeat (100) @(negedge clk);
                chk(rx_data == 8'h11, "R9 data held mid frame", rx_data, 8'h11);
            end
        join
        check_frame("R6 overrun", 8'hE7, 1'b0, 1'b1);
        host_read();
        chk(!overrun && !data_ready, "R7 overrun cleared", overrun, 0);

        // R8 slow and fast senders
        send(8'h55, 8, 18, 1'b1);
        check_frame("R8 slow", 8'h55, 1'b0, 1'b0);
        host_read();
        send(8'hAA, 8, 14, 1'b1);
        check_frame("R8 fast", 8'hAA, 1'b0, 1'b0);
        host_read();

        // R10 tick every second clock
        tick_div = 2;
        send(8'hC3, 8, 32, 1'b1);
        check_frame("R10 half-rate tick", 8'hC3, 1'b0, 1'b0);
        host_read();
        tick_div = 1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule